// File: doc/BRIEF.md
# PS/2 Host Port with Command Transmit

This block is the host side of a two-wire PS/2 link. It watches the clock and data lines for frames that the attached device starts, and it returns each good data byte together with a one-cycle strobe. It can also send a command byte to the device. To do this it pulls the clock line low to stop the device, then releases the clock and clocks the command bits out on edges that the device generates. Both lines are open-drain. Each line therefore has a sense input and a drive-low output, and the pad or the board supplies the pull-up and forms the wired-AND.

A mouse stays silent until it has been told to report. A build-time switch makes the port queue the enable-reporting command (0xF4) as soon as reset ends. That switch is on by default and is turned off for a keyboard port. The device's reply to that command comes back as an ordinary received byte. Frames that fail their checks, and frames that stall for about 2 ms, raise a one-cycle error pulse. In both cases the port returns to idle.

Top module: `ps2h_port`

## Requirements
- R1: While reset is applied, `rx_valid_o` and `err_o` are 0 and neither line is driven, so `ps2_clk_drv_o` and `ps2_dat_drv_o` are both 0.
- R2: A device frame is 11 bits, each sampled on a falling device-clock edge in this order: start 0, eight data bits LSB first, odd parity, stop 1. A good frame puts its data byte on `rx_byte_o` and raises `rx_valid_o` for exactly one cycle per frame.
- R3: A frame with a parity error produces no strobe and raises `err_o` once.
- R4: A frame whose start bit is 1 or whose stop bit is 0 produces no strobe and raises `err_o` once.
- R5: A transmit begins by driving both lines low for exactly INHIBIT_US microseconds of system clock, which is 100 cycles in a 1 MHz configuration. The clock line is then released while the data line stays low, and that low level is the start bit.
- R6: After the request, the port changes the data line only after a falling device-clock edge. On successive edges it presents the eight data bits LSB first, then odd parity, then a released line for the stop bit.
- R7: On the eleventh falling edge the port samples the data line for the device acknowledge. A high level there raises `err_o`, and in either case the transmit ends and `tx_busy_o` drops.
- R8: With INIT_MOUSE = 1, the port sends 0xF4 after reset with no request. With INIT_MOUSE = 0, it never drives the clock line unless a request arrives.
- R9: If a receive or transmit frame sees no falling clock edge for TIMEOUT_US microseconds, the port abandons the frame and raises `err_o`. The next frame is then received or sent correctly from its first bit.
- R10: A transmit request accepted while a device frame is partly received discards the partial frame. It produces neither a strobe nor an error, and the command goes out intact.
- R11: `tx_busy_o` is 1 while the automatic command is pending and from an accepted request until the acknowledge bit. `tx_req_i` is ignored while `tx_busy_o` is 1.
- R12: A low pulse on the clock line shorter than DEB_CYC system cycles is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line |
| ps2_clk_drv_o | output | 1 | 1 pulls the clock line low |
| ps2_dat_i | input | 1 | Sensed level of the PS/2 data line |
| ps2_dat_drv_o | output | 1 | 1 pulls the data line low |
| tx_req_i | input | 1 | Request to send `tx_byte_i` (taken when not busy) |
| tx_byte_i | input | 8 | Command byte to send |
| tx_busy_o | output | 1 | Transmit pending or in progress |
| rx_byte_o | output | 8 | Last good byte received |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| err_o | output | 1 | One-cycle pulse on a bad frame, missing acknowledge or stall |

## Verification
The two functions that can meet in one cycle are receiving a device frame and accepting a host command. The bench provokes this by starting a device frame, stopping after five bits, and raising `tx_req_i` while the receiver holds the partial frame. The result is judged at the ports: no strobe and no error pulse may appear, and the device model must collect the requested byte with correct parity and stop bit. Two more cases are tested. A second request sent while busy must produce no second clock-inhibit sequence, and a receive frame completed after a stall abort must be aligned from its first bit.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_INHIB = 2'd1,
        TX_SEND  = 2'd2
    } tx_st_e;

    // Parity bit that makes the nine bits (data + parity) hold an odd count of ones.
    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
    parameter int DEB_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clk_raw_i,
    input  logic dat_raw_i,
    output logic clk_fall_o,
    output logic dat_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic [1:0]    cs;
        logic [1:0]    ds;
        logic          db;
        logic [CW-1:0] cnt;
        logic          fall;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.cs   = {q.cs[0], clk_raw_i};
        d.ds   = {q.ds[0], dat_raw_i};
        d.fall = 1'b0;
        if (q.cs[1] != q.db) begin
            if (q.cnt == CW'(DEB_CYC - 1)) begin
                d.db   = q.cs[1];
                d.cnt  = '0;
                d.fall = q.db & ~q.cs[1];
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{cs: 2'b11, ds: 2'b11, db: 1'b1, cnt: '0, fall: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign clk_fall_o = q.fall;
    assign dat_o      = q.ds[1];

    // R12
    deb_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.db) |-> ($past(q.cs[1]) == 1'b0));

    // R12
    fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.fall |=> !q.fall);

endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx #(
    parameter int TO_CYC = 2000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fall_i,
    input  logic       dat_i,
    input  logic       abort_i,
    output logic [7:0] byte_o,
    output logic       valid_o,
    output logic       err_o
);
    localparam int WW = $clog2(TO_CYC + 1);

    typedef struct packed {
        logic [9:0]    sr;
        logic [3:0]    cnt;
        logic [WW-1:0] wd;
        logic [7:0]    data;
        logic          valid;
        logic          err;
    } rx_t;

    rx_t q, d;
    logic [10:0] frame;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        frame   = {dat_i, q.sr};
        if (abort_i) begin
            d.cnt = '0;
            d.wd  = '0;
        end else if (fall_i) begin
            d.wd = '0;
            if (q.cnt == 4'd10) begin
                d.cnt = '0;
                if (!frame[0] && frame[10] && (^frame[9:1])) begin
                    d.valid = 1'b1;
                    d.data  = frame[8:1];
                end else begin
                    d.err = 1'b1;
                end
            end else begin
                d.sr  = {dat_i, q.sr[9:1]};
                d.cnt = q.cnt + 1'b1;
            end
        end else if (q.cnt != 4'd0) begin
            if (q.wd == WW'(TO_CYC - 1)) begin
                d.cnt = '0;
                d.wd  = '0;
                d.err = 1'b1;
            end else begin
                d.wd = q.wd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign byte_o  = q.data;
    assign valid_o = q.valid;
    assign err_o   = q.err;

    // R2
    rx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.valid |=> !q.valid);

    // R2
    rx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.valid |-> $past(fall_i));

    // R9
    rx_wd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.wd < WW'(TO_CYC));

endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
    import ps2h_pkg::*;
#(
    parameter int INHIB_CYC = 100,
    parameter int TO_CYC    = 2000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fall_i,
    input  logic       dat_i,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       busy_o,
    output logic       clk_drv_o,
    output logic       dat_drv_o,
    output logic       err_o
);
    localparam int TMAX = (INHIB_CYC > TO_CYC) ? INHIB_CYC : TO_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        tx_st_e        st;
        logic [9:0]    sr;
        logic [3:0]    bi;
        logic [TW-1:0] tmr;
        logic          cdrv;
        logic          ddrv;
        logic          err;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        unique case (q.st)
            TX_IDLE: begin
                if (start_i) begin
                    d.st   = TX_INHIB;
                    d.sr   = {1'b1, odd_parity(byte_i), byte_i};
                    d.bi   = '0;
                    d.tmr  = '0;
                    d.cdrv = 1'b1;
                    d.ddrv = 1'b1;
                end
            end
            TX_INHIB: begin
                if (q.tmr == TW'(INHIB_CYC - 1)) begin
                    d.st   = TX_SEND;
                    d.tmr  = '0;
                    d.cdrv = 1'b0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            TX_SEND: begin
                if (fall_i) begin
                    d.tmr = '0;
                    if (q.bi == 4'd10) begin
                        d.st   = TX_IDLE;
                        d.ddrv = 1'b0;
                        d.err  = dat_i;
                    end else begin
                        d.ddrv = ~q.sr[0];
                        d.sr   = {1'b0, q.sr[9:1]};
                        d.bi   = q.bi + 1'b1;
                    end
                end else if (q.tmr == TW'(TO_CYC - 1)) begin
                    d.st   = TX_IDLE;
                    d.tmr  = '0;
                    d.cdrv = 1'b0;
                    d.ddrv = 1'b0;
                    d.err  = 1'b1;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: TX_IDLE, sr: '0, bi: '0, tmr: '0, cdrv: 1'b0, ddrv: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != TX_IDLE);
    assign clk_drv_o = q.cdrv;
    assign dat_drv_o = q.ddrv;
    assign err_o     = q.err;

    // R5
    start_bit_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(q.cdrv) && q.st == TX_SEND) |-> q.ddrv);

    // R6
    drv_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == TX_SEND && $past(q.st) == TX_SEND && q.ddrv != $past(q.ddrv)) |-> $past(fall_i));

    // R9
    tx_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.tmr < TW'(TMAX));

endmodule

// File: rtl/ps2h_port.sv
module ps2h_port
    import ps2h_pkg::*;
#(
    parameter int       CLK_HZ     = 125_000_000,
    parameter int       INHIBIT_US = 100,
    parameter int       TIMEOUT_US = 2000,
    parameter int       DEB_CYC    = 4,
    parameter bit       INIT_MOUSE = 1'b1,
    parameter bit [7:0] INIT_CMD   = 8'hF4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ps2_clk_i,
    output logic       ps2_clk_drv_o,
    input  logic       ps2_dat_i,
    output logic       ps2_dat_drv_o,
    input  logic       tx_req_i,
    input  logic [7:0] tx_byte_i,
    output logic       tx_busy_o,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       err_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int INHIB_CYC  = CYC_PER_US * INHIBIT_US;
    localparam int TO_CYC     = CYC_PER_US * TIMEOUT_US;

    typedef struct packed {
        logic init_pend;
    } top_t;

    top_t q, d;

    logic       fall, dat_s;
    logic       tx_active, launch, rx_err, tx_err;
    logic [7:0] cmd;

    always_comb begin
        d      = q;
        launch = (q.init_pend | tx_req_i) & ~tx_active;
        cmd    = q.init_pend ? INIT_CMD : tx_byte_i;
        if (q.init_pend && !tx_active) begin
            d.init_pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{init_pend: INIT_MOUSE};
        end else begin
            q <= d;
        end
    end

    ps2h_sync #(.DEB_CYC(DEB_CYC)) sync_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clk_raw_i  (ps2_clk_i),
        .dat_raw_i  (ps2_dat_i),
        .clk_fall_o (fall),
        .dat_o      (dat_s)
    );

    ps2h_rx #(.TO_CYC(TO_CYC)) rx_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fall_i  (fall),
        .dat_i   (dat_s),
        .abort_i (tx_busy_o | launch),
        .byte_o  (rx_byte_o),
        .valid_o (rx_valid_o),
        .err_o   (rx_err)
    );

    ps2h_tx #(.INHIB_CYC(INHIB_CYC), .TO_CYC(TO_CYC)) tx_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_i    (fall),
        .dat_i     (dat_s),
        .start_i   (launch),
        .byte_i    (cmd),
        .busy_o    (tx_active),
        .clk_drv_o (ps2_clk_drv_o),
        .dat_drv_o (ps2_dat_drv_o),
        .err_o     (tx_err)
    );

    assign tx_busy_o = tx_active | q.init_pend;
    assign err_o     = rx_err | tx_err;

    // R10
    no_rx_while_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_busy_o |-> !rx_valid_o);

    // R11
    busy_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ps2_clk_drv_o |-> tx_busy_o);

endmodule

// File: tb/ps2h_port_tb.sv
module ps2h_port_tb_top;
    localparam int HALF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic cdrv, ddrv, busy, rx_valid, err;
    logic [7:0] rx_byte;
    logic tx_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic clk_line, dat_line;
    assign clk_line = dev_clk & ~cdrv;
    assign dat_line = dev_dat & ~ddrv;

    ps2h_port #(.CLK_HZ(1_000_000), .INHIBIT_US(100), .TIMEOUT_US(2000),
                .DEB_CYC(4), .INIT_MOUSE(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ps2_clk_i(clk_line), .ps2_clk_drv_o(cdrv),
        .ps2_dat_i(dat_line), .ps2_dat_drv_o(ddrv),
        .tx_req_i(tx_req), .tx_byte_i(tx_byte), .tx_busy_o(busy),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .err_o(err)
    );

    logic kb_cdrv, kb_ddrv, kb_busy, kb_valid, kb_err;
    logic [7:0] kb_byte;
    ps2h_port #(.CLK_HZ(1_000_000), .INHIBIT_US(100), .TIMEOUT_US(2000),
                .DEB_CYC(4), .INIT_MOUSE(1'b0)) kb_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ps2_clk_i(~kb_cdrv), .ps2_clk_drv_o(kb_cdrv),
        .ps2_dat_i(~kb_ddrv), .ps2_dat_drv_o(kb_ddrv),
        .tx_req_i(1'b0), .tx_byte_i(8'h00), .tx_busy_o(kb_busy),
        .rx_byte_o(kb_byte), .rx_valid_o(kb_valid), .err_o(kb_err)
    );

    int n_tests = 0, n_fail = 0;
    int n_valid = 0, n_err = 0, n_starts = 0, n_wide = 0, n_kb_drv = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0, prev_cdrv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin n_valid++; last_byte = rx_byte; end
            if (rx_valid && prev_valid) n_wide++;
            if (err) n_err++;
            if (cdrv && !prev_cdrv) n_starts++;
            if (kb_cdrv) n_kb_drv++;
        end
        prev_valid = rx_valid;
        prev_cdrv  = cdrv;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dev_send(input logic [7:0] b, input bit bad_start, input bit bad_par,
                            input bit bad_stop, input int nbits, input bit glitch);
        logic [10:0] f;
        f = {~bad_stop, (~(^b)) ^ bad_par, b, bad_start};
        for (int i = 0; i < nbits; i++) begin
            if (glitch && i == 5) begin
                wcyc(3); dev_clk = 1'b0; wcyc(2); dev_clk = 1'b1;
            end
            dev_dat = f[i];
            wcyc(HALF);
            dev_clk = 1'b0;
            wcyc(HALF);
            dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        wcyc(4);
    endtask

    task automatic dev_recv(input bit ack, output logic [7:0] got, output bit par_ok,
                            output bit stop_ok, output bit start_ok, output int inhib_len,
                            output bit dat_held);
        logic [10:0] bits;
        bits = '0;
        inhib_len = 0;
        while (!cdrv) @(negedge clk);
        while (cdrv) begin inhib_len++; @(negedge clk); end
        dat_held = ddrv;
        start_ok = !dat_line;
        wcyc(HALF);
        for (int k = 1; k <= 10; k++) begin
            dev_clk = 1'b0;
            wcyc(HALF);
            dev_clk = 1'b1;
            bits[k] = dat_line;
            wcyc(HALF);
        end
        dev_dat = ack ? 1'b0 : 1'b1;
        dev_clk = 1'b0;
        wcyc(HALF);
        dev_clk = 1'b1;
        wcyc(HALF);
        dev_dat = 1'b1;
        wcyc(4);
        got     = bits[8:1];
        par_ok  = ^bits[9:1];
        stop_ok = bits[10];
    endtask

    task automatic request(input logic [7:0] b);
        tx_byte = b;
        tx_req  = 1'b1;
        wcyc(1);
        tx_req  = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] got;
        bit par_ok, stop_ok, start_ok, held;
        int len, v0, e0, s0;

        wcyc(5);
        // R1 reset state
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 err", err, 0);
        chk("R1 drv", {cdrv, ddrv, kb_cdrv, kb_ddrv}, 0);
        rst_n = 1'b1;
        wcyc(1);
        // R11 busy while init pending, R8 keyboard idle
        chk("R11 init busy", busy, 1);
        chk("R8 kb not busy", kb_busy, 0);

        // R8 automatic enable command, R5 inhibit shape
        dev_recv(1'b1, got, par_ok, stop_ok, start_ok, len, held);
        chk("R8 init byte", got, 8'hF4);
        chk("R6 init parity/stop/start", {par_ok, stop_ok, start_ok}, 3'b111);
        chk("R5 inhibit cycles", len, 100);
        chk("R5 data held at release", held, 1);
        chk("R7 ack ok no err", n_err, 0);
        chk("R11 busy after ack", busy, 0);

        // R8 device acknowledge reported as ordinary byte
        dev_send(8'hFA, 0, 0, 0, 11, 0);
        chk("R8 ack byte count", n_valid, 1);
        chk("R8 ack byte", last_byte, 8'hFA);
        chk("R8 kb never drove", n_kb_drv, 0);

        // R2 exhaustive receive sweep
        for (int b = 0; b < 256; b++) begin
            v0 = n_valid;
            dev_send(8'(b), 0, 0, 0, 11, 0);
            chk("R2 rx sweep", ((n_valid - v0) << 8) | int'(last_byte), 256 | b);
        end
        chk("R2 strobe width", n_wide, 0);
        chk("R2 no err in sweep", n_err, 0);

        // R3 parity errors
        for (int i = 0; i < 3; i++) begin
            v0 = n_valid; e0 = n_err;
            dev_send((i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'hA5, 0, 1, 0, 11, 0);
            chk("R3 bad parity", ((n_valid - v0) << 4) | (n_err - e0), 1);
        end

        // R4 start and stop errors
        v0 = n_valid; e0 = n_err;
        dev_send(8'h3E, 1, 0, 0, 11, 0);
        chk("R4 bad start", ((n_valid - v0) << 4) | (n_err - e0), 1);
        v0 = n_valid; e0 = n_err;
        dev_send(8'h81, 0, 0, 1, 11, 0);
        chk("R4 bad stop", ((n_valid - v0) << 4) | (n_err - e0), 1);

        // R12 glitch rejected
        v0 = n_valid; e0 = n_err;
        dev_send(8'h6B, 0, 0, 0, 11, 1);
        chk("R12 glitch frame", ((n_valid - v0) << 12) | ((n_err - e0) << 8) | int'(last_byte),
            (1 << 12) | 8'h6B);

        // R9 receive stall then realign
        v0 = n_valid; e0 = n_err;
        dev_send(8'h00, 0, 0, 0, 4, 0);
        wcyc(2100);
        chk("R9 rx stall err", ((n_valid - v0) << 4) | (n_err - e0), 1);
        dev_send(8'h5A, 0, 0, 0, 11, 0);
        chk("R9 rx realign", ((n_valid - v0) << 8) | int'(last_byte), 256 | 8'h5A);

        // R6 transmit sweep
        for (int i = 0; i < 16; i++) begin
            e0 = n_err;
            request(8'(i * 17));
            dev_recv(1'b1, got, par_ok, stop_ok, start_ok, len, held);
            chk("R6 tx byte", got, i * 17);
            chk("R6 tx framing", {par_ok, stop_ok, start_ok, held, (n_err == e0)}, 5'b11111);
        end

        // R11 request while busy ignored
        s0 = n_starts;
        request(8'hC3);
        chk("R11 busy after request", busy, 1);
        wcyc(5);
        request(8'h11);
        dev_recv(1'b1, got, par_ok, stop_ok, start_ok, len, held);
        chk("R11 first byte sent", got, 8'hC3);
        wcyc(300);
        chk("R11 single start", n_starts - s0, 1);

        // R7 missing acknowledge
        e0 = n_err;
        request(8'h42);
        dev_recv(1'b0, got, par_ok, stop_ok, start_ok, len, held);
        chk("R7 no ack err", n_err - e0, 1);
        chk("R7 busy cleared", busy, 0);

        // R10 request during a partial receive
        v0 = n_valid; e0 = n_err;
        dev_send(8'hFF, 0, 0, 0, 5, 0);
        request(8'h3C);
        dev_recv(1'b1, got, par_ok, stop_ok, start_ok, len, held);
        chk("R10 tx byte", got, 8'h3C);
        chk("R10 parity/stop", {par_ok, stop_ok}, 2'b11);
        wcyc(2100);
        chk("R10 no strobe no err", ((n_valid - v0) << 4) | (n_err - e0), 0);

        // R9 transmit stall
        e0 = n_err;
        request(8'h77);
        wcyc(100 + 2000 + 50);
        chk("R9 tx stall err", n_err - e0, 1);
        chk("R9 tx released", {busy, cdrv, ddrv}, 0);
        request(8'h96);
        dev_recv(1'b1, got, par_ok, stop_ok, start_ok, len, held);
        chk("R9 tx after stall", got, 8'h96);

        summary();
        $finish;
    end

endmodule